// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address of each beat of a four-beat burst. When the front end accepts an address strobe, it raises `load` for one cycle. The sequencer then captures the full start address. The two low bits seed the burst, and the upper bits are held unchanged for the whole burst.

On each later cycle, an active-low advance steps the burst to its next beat. When advance is inactive, the current beat is held, which suspends the burst. A static strap selects one of two beat orders:

- **Linear:** the low bits count up by one and wrap modulo four.
- **Interleaved:** the low bits are the start value XORed with the beat number.

The block performs no memory access and decodes no writes. It also does not judge whether a strobe should be accepted; the front end makes that decision.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the edge clears the beat index and the held address. After reset, `addr_o` and `beat_o` both read 0.
- R2: A rising edge with `load` high captures `start_addr` into the held address and sets `beat_o` to 0. From the next cycle, `addr_o` equals `start_addr`.
- R3: On a load edge, `advance_n` is ignored. A load with `advance_n` low still gives `beat_o` = 0.
- R4: A rising edge with `load` low and `advance_n` low (active) adds one to `beat_o`, modulo 4.
- R5: A rising edge with `load` low and `advance_n` high leaves `addr_o` and `beat_o` unchanged. This is the suspend case.
- R6: With `mode` = 1 (interleaved), the low two bits of `addr_o` equal the captured low two bits XOR `beat_o`. For example, start 10 gives 10, 11, 00, 01.
- R7: With `mode` = 0 (linear), the low two bits of `addr_o` equal the captured low two bits plus `beat_o`, modulo 4. For example, start 11 gives 11, 00, 01, 10.
- R8: Between loads, bits `[ADDR_W-1:2]` of `addr_o` never change, so the burst stays inside its aligned group of four.
- R9: Advancing from beat 3 wraps `beat_o` to 0, and the low bits return to the captured start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Accepted address strobe; captures `start_addr` |
| advance_n | input | 1 | Step to next beat when low; hold when high |
| mode | input | 1 | Order strap: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Start address of the burst |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | 2 | Beats advanced since load, modulo 4 |

## Verification
The assertions take `mode` to be a strap that does not move while the block is running. The hold and wrap checks compare `addr_o` across edges, and a strap change in the middle of a burst would change `addr_o` without any load or step. The stimulus therefore changes `mode` only while `rst` is high. Within each strap setting, it sweeps every start address. The advance pattern mixes steps, suspends and a full wrap, and includes loads issued with advance low.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  // Low address bits for a given beat in the selected order.
  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] base,
    input logic [BEAT_W-1:0] beat,
    input order_e            order
  );
    logic [BEAT_W-1:0] r;
    if (order == ORDER_XOR) r = base ^ beat;
    else                    r = base + beat;
    return r;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_next(input logic [BEAT_W-1:0] beat);
    return beat + 1'b1;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst)         beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_next(beat_q);
  end

  assign beat_o = beat_q;

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1))); // R4
  AST_BEAT_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_o == '0)); // R3
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [ADDR_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)         q_r <= '0;
    else if (load_i) q_r <= start_i;
  end

  assign q_o = q_r;

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(start_i))); // R2
  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] low_w;
  order_e            order_w;

  assign order_w = order_e'(mode_i);
  assign low_w   = beat_low(base_i[BEAT_W-1:0], beat_i, order_w);

  generate
    if (HI_W > 0) begin : g_upper
      assign addr_o = {base_i[ADDR_W-1:BEAT_W], low_w};
    end else begin : g_low_only
      assign addr_o = low_w;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  // Named internal events for the checks below.
  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_w;
  logic [BEAT_W-1:0] beat_w;

  assign load_evt = load;
  assign step_evt = !advance_n;

  burst_start_reg #(.ADDR_W(ADDR_W)) start_reg_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_evt),
    .start_i(start_addr),
    .q_o    (base_w)
  );

  burst_beat_ctr beat_ctr_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_evt),
    .step_i(step_evt),
    .beat_o(beat_w)
  );

  burst_order_map #(.ADDR_W(ADDR_W)) order_map_i (
    .base_i(base_w),
    .beat_i(beat_w),
    .mode_i(mode),
    .addr_o(addr_o)
  );

  assign beat_o = beat_w;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (beat_o == '0 && addr_o == '0)); // R1
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_evt && !step_evt) |=> ($stable(addr_o) && $stable(beat_o))); // R5
  AST_BEAT0_IS_START: assert property (@(posedge clk) disable iff (rst)
    (beat_o == '0) |-> (addr_o == base_w)); // R6 R7
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
    (!load_evt && step_evt && beat_o == 2'd3) |=>
      (beat_o == '0 && addr_o[BEAT_W-1:0] == base_w[BEAT_W-1:0])); // R9
  AST_GROUP_FIXED: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]))); // R8
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic          advance_n = 1'b1;
  logic          mode = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int checks = 0;
  int errors = 0;

  // Bench-side reference state.
  logic [AW-1:0] m_start;
  logic [1:0]    m_beat;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .advance_n (advance_n),
    .mode      (mode),
    .start_addr(start_addr),
    .addr_o    (addr_o),
    .beat_o    (beat_o)
  );

  function automatic logic [AW-1:0] exp_addr(
    input logic [AW-1:0] s,
    input logic [1:0]    b,
    input logic          md
  );
    logic [1:0] lo;
    lo = md ? (s[1:0] ^ b) : 2'((int'(s[1:0]) + int'(b)) % 4);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: apply inputs, advance the reference, then compare.
  task automatic cyc(input logic ld, input logic adv_n, input logic [AW-1:0] st,
                     input string tag);
    load = ld; advance_n = adv_n; start_addr = st;
    @(posedge clk); #1;
    if (rst) begin m_start = '0; m_beat = '0; end
    else if (ld) begin m_start = st; m_beat = '0; end
    else if (!adv_n) m_beat = m_beat + 2'd1;
    check({tag, " beat"}, int'(beat_o), int'(m_beat));
    check({tag, " addr"}, int'(addr_o), int'(exp_addr(m_start, m_beat, mode)));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_start = '0; m_beat = '0;
    for (int md = 0; md < 2; md++) begin
      rst = 1'b1; mode = md[0];
      cyc(1'b1, 1'b0, 6'h2a, "R1 reset");
      cyc(1'b0, 1'b1, '0, "R1 reset");
      rst = 1'b0;
      cyc(1'b0, 1'b1, '0, "R1 after reset");
      for (int s = 0; s < (1 << AW); s++) begin
        // R3: load with advance active.
        cyc(1'b1, 1'b0, AW'(s), "R2 R3 load");
        cyc(1'b0, 1'b0, '0, md ? "R4 R6 step" : "R4 R7 step");
        cyc(1'b0, 1'b1, 6'h3f, "R5 suspend");
        cyc(1'b0, 1'b0, '0, md ? "R6 step" : "R7 step");
        cyc(1'b0, 1'b0, '0, "R8 step");
        cyc(1'b0, 1'b0, '0, "R9 wrap");
        cyc(1'b0, 1'b1, '0, "R5 hold");
        cyc(1'b0, 1'b0, '0, "R9 past wrap");
      end
      // Load in the middle of a burst restarts at beat 0.
      cyc(1'b1, 1'b1, 6'h11, "R2 load");
      cyc(1'b0, 1'b0, '0, "R4 step");
      cyc(1'b1, 1'b0, 6'h26, "R3 reload");
      cyc(1'b0, 1'b0, '0, "R8 step");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule